// File: doc/BRIEF.md
# Single-Port SRAM FIFO Controller

This block runs a deep first-in first-out queue whose storage is an external single-port SRAM. Writers and readers each raise a request. While the controller is idle it grants at most one of them. It then spends exactly two clock cycles on the SRAM access, holding either the write strobe or the output enable. After those two cycles it retires the operation.

All bookkeeping happens in one clock domain. A single occupancy counter moves up by one when a write retires, down by one when a read retires, and otherwise holds. The full flag, the empty flag and the exact fill level all come from this counter. Separate read and write address pointers select the SRAM location and wrap at the configured depth. When both sides are waiting and both are allowed, grants alternate so that neither side starves.

A request is accepted in the cycle where it is high and its grant output is high. Write data is captured in that same cycle. Read data appears with a one-cycle valid pulse after the access completes.

Top module: `sram_fifo_ctrl`

## Requirements
- R1: After reset, level is 0, empty is 1, full is 0, and sram_we, sram_oe and rd_valid are 0.
- R2: A write is granted only while idle and not full. wr_gnt is high in the request cycle. In each of the next two cycles, sram_we is 1, sram_addr holds the write pointer and sram_wdata holds the accepted data. The strobe never lasts any other number of cycles.
- R3: A granted read holds sram_oe for the two cycles after the grant. In the cycle after those two, rd_valid is 1 for one cycle, and rd_data carries the oldest stored word in first-in first-out order.
- R4: level rises by one at the clock edge that ends the second cycle of a write access. It falls by one at the edge that ends the second cycle of a read access. At all other times it holds.
- R5: empty is 1 exactly when level is 0, and full is 1 exactly when level equals DEPTH.
- R6: A write request while full gets no grant and causes no write strobe. level and the pointers are unchanged.
- R7: A read request while empty gets no grant and causes no output enable. level and the pointers are unchanged.
- R8: When both requests are high and both are allowed while idle, the side opposite to the last granted operation wins. After reset, the write side counts as next.
- R9: The write pointer and the read pointer each advance by one per retired access and return to 0 after DEPTH-1.
- R10: sram_we and sram_oe are never 1 together, wr_gnt and rd_gnt are never 1 together, and no grant is given during an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request |
| wr_data | input | DW | Word to store, captured on grant |
| wr_gnt | output | 1 | Write accepted this cycle |
| rd_req | input | 1 | Read request |
| rd_gnt | output | 1 | Read accepted this cycle |
| rd_data | output | DW | Word read back |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| level | output | CW | Current number of stored words |
| full | output | 1 | level equals DEPTH |
| empty | output | 1 | level equals 0 |
| sram_addr | output | CW | SRAM address |
| sram_wdata | output | DW | SRAM write data |
| sram_rdata | input | DW | SRAM read data |
| sram_we | output | 1 | SRAM write enable, active high |
| sram_oe | output | 1 | SRAM output enable, active high |

## Verification
A grant is a combinational answer in the same cycle as its request. The SRAM strobes follow in the two cycles after that edge. level, the flags, rd_valid and rd_data change at the third edge. The bench drives requests at the falling edge and reads the grant a moment later. It checks the strobe, the address and the data at the falling edge after the grant edge. It checks the retired result at the falling edge after the third edge, and it confirms in the following cycle that rd_valid has dropped again. Refusals are checked by holding a request for several cycles, then confirming that no grant appeared, no strobe started and level did not move.

// File: rtl/sram_fifo_ctrl.sv
module sram_fifo_ctrl #(
  parameter int CW    = 20,
  parameter int DW    = 16,
  parameter int DEPTH = (1 << CW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          wr_gnt,
  input  logic          rd_req,
  output logic          rd_gnt,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] sram_addr,
  output logic [DW-1:0] sram_wdata,
  input  logic [DW-1:0] sram_rdata,
  output logic          sram_we,
  output logic          sram_oe
);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);
  localparam logic [CW-1:0] TOP  = CW'(DEPTH);

  typedef enum logic [1:0] {IDLE, PH1, PH2} st_t;
  st_t st;

  logic          op_wr, last_wr;
  logic [CW-1:0] wptr, rptr, cnt;
  logic [DW-1:0] wbuf;
  logic          idle, wr_ok, rd_ok, pick_wr;

  assign idle    = (st == IDLE);
  assign full    = (cnt == TOP);
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign wr_ok   = wr_req && !full;
  assign rd_ok   = rd_req && !empty;
  assign pick_wr = wr_ok && (!rd_ok || !last_wr);
  assign wr_gnt  = idle && pick_wr;
  assign rd_gnt  = idle && rd_ok && !pick_wr;

  assign sram_we    = !idle && op_wr;
  assign sram_oe    = !idle && !op_wr;
  assign sram_addr  = op_wr ? wptr : rptr;
  assign sram_wdata = wbuf;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      op_wr    <= 1'b0;
      last_wr  <= 1'b0;
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      wbuf     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        IDLE: if (wr_gnt || rd_gnt) begin
          st      <= PH1;
          op_wr   <= wr_gnt;
          last_wr <= wr_gnt;
          if (wr_gnt) wbuf <= wr_data;
        end
        PH1: st <= PH2;
        default: begin
          st <= IDLE;
          if (op_wr) begin
            wptr <= step(wptr);
            cnt  <= cnt + 1'b1;
          end else begin
            rptr     <= step(rptr);
            cnt      <= cnt - 1'b1;
            rd_data  <= sram_rdata;
            rd_valid <= 1'b1;
          end
        end
      endcase
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_we && sram_oe));
  assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_gnt && rd_gnt));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_gnt);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_gnt);
  assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP);
  assert_two_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gnt ##1 sram_we) |=> sram_we);
  assert_we_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && $past(sram_we)) |=> !sram_we);
  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && $past(sram_we)) |=> level == $past(level) + 1'b1);
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_oe && $past(sram_oe)) |=> (level == $past(level) - 1'b1) && rd_valid);
  assert_alternate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && wr_ok && rd_ok && last_wr) |-> rd_gnt);
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we || sram_oe) |-> !(wr_gnt || rd_gnt));
endmodule

// File: tb/sram_fifo_ctrl_bench.sv
module sram_fifo_ctrl_bench;
  localparam int CW = 20, DW = 8, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic wr_req = 0, rd_req = 0;
  logic [DW-1:0] wr_data = 0;
  logic wr_gnt, rd_gnt, rd_valid, full, empty, sram_we, sram_oe;
  logic [DW-1:0] rd_data, sram_wdata, sram_rdata;
  logic [CW-1:0] level, sram_addr;

  sram_fifo_ctrl #(.CW(CW), .DW(DW), .DEPTH(DEPTH)) u_sram_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data), .wr_gnt(wr_gnt),
    .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_data(rd_data), .rd_valid(rd_valid),
    .level(level), .full(full), .empty(empty), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .sram_we(sram_we), .sram_oe(sram_oe));

  always #2 clk = ~clk;

  logic [DW-1:0] mem [0:7];
  always @(posedge clk) if (sram_we) mem[sram_addr[2:0]] <= sram_wdata;
  assign sram_rdata = sram_oe ? mem[sram_addr[2:0]] : '0;

  int checks = 0, errors = 0, we_len = 0, oe_len = 0, bad_len = 0, overlaps = 0;
  int we_starts = 0, oe_starts = 0, exp_w = 0, exp_r = 0;
  bit done = 0;
  int q[$];

  always @(negedge clk) if (rst_n) begin
    if (sram_we && sram_oe) overlaps++;
    if (sram_we) begin if (we_len == 0) we_starts++; we_len++; end
    else begin if (we_len != 0 && we_len != 2) bad_len++; we_len = 0; end
    if (sram_oe) begin if (oe_len == 0) oe_starts++; oe_len++; end
    else begin if (oe_len != 0 && oe_len != 2) bad_len++; oe_len = 0; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_write(input int d);
    @(negedge clk); wr_req = 1; wr_data = DW'(d); #1;
    chk("R2 wr_gnt", wr_gnt, 1);
    @(posedge clk); #1 wr_req = 0;
    chk("R2 sram_we", sram_we, 1);
    chk("R9 write address", int'(sram_addr), exp_w);
    chk("R2 sram_wdata", int'(sram_wdata), d);
    @(posedge clk); @(posedge clk); @(negedge clk);
    q.push_back(d); exp_w = (exp_w + 1) % DEPTH;
    chk("R4 level after write", int'(level), q.size());
    chk("R5 empty", empty, q.size() == 0);
    chk("R5 full", full, q.size() == DEPTH);
  endtask

  task automatic do_read;
    int e;
    @(negedge clk); rd_req = 1; #1;
    chk("R3 rd_gnt", rd_gnt, 1);
    @(posedge clk); #1 rd_req = 0;
    chk("R3 sram_oe", sram_oe, 1);
    chk("R9 read address", int'(sram_addr), exp_r);
    @(posedge clk); @(posedge clk); @(negedge clk);
    e = q.pop_front(); exp_r = (exp_r + 1) % DEPTH;
    chk("R3 rd_valid", rd_valid, 1);
    chk("R3 rd_data order", int'(rd_data), e);
    chk("R4 level after read", int'(level), q.size());
    chk("R5 empty", empty, q.size() == 0);
    @(negedge clk);
    chk("R3 rd_valid single pulse", rd_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 level", int'(level), 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 strobes", sram_we | sram_oe | rd_valid, 0);
  endtask

  task automatic t_refuse_write;
    int s = we_starts; int g = 0;
    @(negedge clk); wr_req = 1; wr_data = 8'hEE;
    repeat (4) begin #1; g |= wr_gnt; @(negedge clk); end
    wr_req = 0; #1;
    chk("R6 no grant when full", g, 0);
    chk("R6 no write strobe", we_starts, s);
    chk("R6 level held", int'(level), DEPTH);
  endtask

  task automatic t_refuse_read;
    int s = oe_starts; int g = 0;
    @(negedge clk); rd_req = 1;
    repeat (4) begin #1; g |= rd_gnt; @(negedge clk); end
    rd_req = 0; #1;
    chk("R7 no grant when empty", g, 0);
    chk("R7 no output enable", oe_starts, s);
    chk("R7 level held", int'(level), 0);
  endtask

  task automatic t_alternate;
    int d = 8'h70;
    int seq[4];
    @(negedge clk); wr_req = 1; rd_req = 1; wr_data = DW'(d); #1;
    for (int i = 0; i < 4; i++) begin
      while (!(wr_gnt || rd_gnt)) begin @(negedge clk); #1; end
      seq[i] = wr_gnt;
      if (wr_gnt) begin q.push_back(d); exp_w = (exp_w + 1) % DEPTH; end
      else begin void'(q.pop_front()); exp_r = (exp_r + 1) % DEPTH; end
      @(posedge clk); #1;
      if (seq[i] == 1) begin d++; wr_data = DW'(d); end
    end
    wr_req = 0; rd_req = 0;
    repeat (3) @(negedge clk);
    chk("R8 first tie goes to read after writes", seq[0], 0);
    chk("R8 second tie write", seq[1], 1);
    chk("R8 third tie read", seq[2], 0);
    chk("R8 fourth tie write", seq[3], 1);
    chk("R4 level after alternation", int'(level), q.size());
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    do_write(8'hA5);
    do_read();
    for (int i = 0; i < DEPTH - 1; i++) do_write(8'h10 + i);
    chk("R5 not full one short", full, 0);
    do_write(8'h1F);
    t_refuse_write();
    for (int i = 0; i < DEPTH; i++) do_read();
    t_refuse_read();
    for (int i = 0; i < 3; i++) begin do_write(8'h40 + i); do_read(); end
    do_write(8'h51); do_write(8'h52);
    t_alternate();
    while (q.size() > 0) do_read();
    chk("R2 R3 strobe length", bad_len, 0);
    chk("R10 strobe overlap", overlaps, 0);
    finish_run();
  end
endmodule